// File: doc/BRIEF.md
# Slow-Control Command Splitter with Hardware Timing Actions

This block sits between the downlink byte decoder and the board processor. It watches the slow-control byte stream, which arrives at a few hundred kilobits per second and so delivers a byte only every few hundred clock cycles. It assembles the bytes into four-byte frames and checks each frame's checksum. Timing-calibration frames are carried out directly in logic, so their effect appears a fixed number of clock cycles after the frame ends. No software latency adds jitter to the measurement. These frames can fire a calibration LED on one of eight digital I/O lines, reset the timestamp counter, set the pulse width, or set static levels on the lines.

Every frame that is not a calibration frame is handed to the processor through a small frame FIFO, as one 32-bit word. A frame is therefore forwarded whole or not at all. Frames with a bad checksum are dropped and counted.

Top module: `sc_cmd_parser`

## Requirements
- R1: After reset, `dio_o` is 0, `tr_rst_o` is 0, `fwd_valid_o` is 0 and `err_cnt_o` is 0.
- R2: A frame is the sync byte 0xA5, then an opcode byte, an argument byte and a checksum byte equal to (opcode + argument) mod 256. Only cycles with `rx_valid_i` high carry bytes, and idle cycles may separate them. While the block waits for a sync byte, any other byte is ignored.
- R3: A frame with a wrong checksum is neither executed nor forwarded. It raises `err_cnt_o` by one in the cycle after its checksum byte is accepted. The counter saturates at 255.
- R4: Opcode 0x80 drives `tr_rst_o` high for exactly the one cycle that follows the clock edge on which its checksum byte is accepted.
- R5: Opcode 0x81 pulses line `arg[2:0]` of `dio_o`, and argument bits 7:3 are ignored. The line is high from LED_DELAY (3) cycles after the acceptance edge, for the programmed pulse length in cycles.
- R6: Opcode 0x82 sets the pulse length to the argument, and an argument of 0 gives a length of 1. The length after reset is 4.
- R7: Opcode 0x83 sets the static levels of the eight lines to the argument. `dio_o` is the static levels ORed with the active pulse.
- R8: An 0x81 frame accepted while an earlier pulse is still waiting or still high has no effect.
- R9: Opcodes 0x84 to 0x8F are consumed with no effect on any output, and they are not forwarded.
- R10: Every opcode outside 0x80 to 0x8F is forwarded as `fwd_data_o` = {0xA5, opcode, argument, checksum}, sync byte in bits 31:24. Frames leave in arrival order, and one frame is removed per cycle with `fwd_valid_o` and `fwd_ready_i` both high.
- R11: The FIFO holds FWD_DEPTH (4) frames. A frame accepted while it is full is dropped entirely. `fwd_data_o` holds steady while `fwd_valid_o` is high and `fwd_ready_i` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid_i | input | 1 | A received byte is present this cycle |
| rx_byte_i | input | 8 | Received slow-control byte |
| dio_o | output | 8 | Digital I/O drive lines |
| tr_rst_o | output | 1 | One-cycle time-register reset |
| fwd_valid_o | output | 1 | A forwarded frame is available |
| fwd_data_o | output | 32 | Forwarded frame, sync byte in top byte |
| fwd_ready_i | input | 1 | Processor takes the frame this cycle |
| err_cnt_o | output | 8 | Saturating checksum-error count |

## Verification
The LED path is swept over all eight lines and several pulse lengths, including the zero argument, with upper argument bits varied. The output is sampled every cycle, so an off-by-one in the delay or the width shows at a single sample. Every opcode outside the executed four is sent once, which separates the forwarded range from the reserved calibration range at both edges of 0x80 to 0x8F. Gapped frames, stray bytes before the sync byte, bad checksums, a FIFO filled past capacity and a run of bad frames past 255 each exercise one corner of the framing, drop or saturation logic.

// File: rtl/sc_cmd_parser.sv
`timescale 1ns/1ps
module sc_cmd_parser #(
  parameter logic [7:0] SYNC_BYTE     = 8'hA5,
  parameter int         LED_DELAY     = 3,
  parameter int         PULSE_LEN_RST = 4,
  parameter int         FWD_DEPTH     = 4,
  parameter int         ERR_W         = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid_i,
  input  logic [7:0]  rx_byte_i,
  output logic [7:0]  dio_o,
  output logic        tr_rst_o,
  output logic        fwd_valid_o,
  output logic [31:0] fwd_data_o,
  input  logic        fwd_ready_i,
  output logic [ERR_W-1:0] err_cnt_o
);
  localparam int PTR_W = $clog2(FWD_DEPTH);
  localparam int CNT_W = $clog2(FWD_DEPTH + 1);
  localparam int DLY_W = $clog2(LED_DELAY + 1);

  typedef enum logic [1:0] {S_SYNC, S_OP, S_ARG, S_CHK} state_t;

  state_t            state_q;
  logic [7:0]        op_q, arg_q;
  logic [7:0]        lvl_q, plen_q, wid_q;
  logic [2:0]        sel_q;
  logic              pend_q, on_q;
  logic [DLY_W-1:0]  dly_q;
  logic [31:0]       mem_q [FWD_DEPTH];
  logic [PTR_W-1:0]  wr_q, rd_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [7:0]        led_mask;

  wire [7:0] sum    = op_q + arg_q;
  wire accept       = rx_valid_i && (state_q == S_CHK);
  wire good         = accept && (sum == rx_byte_i);
  wire bad          = accept && (sum != rx_byte_i);
  wire is_hw        = (op_q[7:4] == 4'h8);
  wire cmd_trst     = good && (op_q == 8'h80);
  wire cmd_led      = good && (op_q == 8'h81);
  wire cmd_len      = good && (op_q == 8'h82);
  wire cmd_lvl      = good && (op_q == 8'h83);
  wire full         = (cnt_q == CNT_W'(FWD_DEPTH));
  wire push         = good && !is_hw && !full;
  wire pop          = fwd_valid_o && fwd_ready_i;

  assign led_mask    = on_q ? (8'b1 << sel_q) : 8'b0;
  assign dio_o       = lvl_q | led_mask;
  assign fwd_valid_o = (cnt_q != '0);
  assign fwd_data_o  = mem_q[rd_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_SYNC;
      op_q    <= '0;
      arg_q   <= '0;
    end else if (rx_valid_i) begin
      case (state_q)
        S_SYNC: if (rx_byte_i == SYNC_BYTE) state_q <= S_OP;
        S_OP:   begin op_q  <= rx_byte_i; state_q <= S_ARG; end
        S_ARG:  begin arg_q <= rx_byte_i; state_q <= S_CHK; end
        default: state_q <= S_SYNC;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tr_rst_o  <= 1'b0;
      lvl_q     <= '0;
      plen_q    <= 8'(PULSE_LEN_RST);
      err_cnt_o <= '0;
    end else begin
      tr_rst_o <= cmd_trst;
      if (cmd_lvl) lvl_q <= arg_q;
      if (cmd_len) plen_q <= (arg_q == 8'd0) ? 8'd1 : arg_q;
      if (bad && (err_cnt_o != '1)) err_cnt_o <= err_cnt_o + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      on_q   <= 1'b0;
      dly_q  <= '0;
      wid_q  <= '0;
      sel_q  <= '0;
    end else if (cmd_led && !pend_q && !on_q) begin
      pend_q <= 1'b1;
      dly_q  <= DLY_W'(LED_DELAY - 1);
      sel_q  <= arg_q[2:0];
    end else if (pend_q) begin
      if (dly_q == '0) begin
        pend_q <= 1'b0;
        on_q   <= 1'b1;
        wid_q  <= plen_q - 8'd1;
      end else begin
        dly_q <= dly_q - 1'b1;
      end
    end else if (on_q) begin
      if (wid_q == 8'd0) on_q <= 1'b0;
      else wid_q <= wid_q - 8'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= wr_q + 1'b1;
      if (pop)  rd_q <= rd_q + 1'b1;
      cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wr_q] <= {SYNC_BYTE, op_q, arg_q, rx_byte_i};
  end
endmodule

// File: rtl/sc_cmd_parser_chk.sv
`timescale 1ns/1ps
module sc_cmd_parser_chk #(
  parameter int FWD_DEPTH = 4,
  parameter int ERR_W     = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tr_rst_o,
  input logic             fwd_valid_o,
  input logic             fwd_ready_i,
  input logic [31:0]      fwd_data_o,
  input logic [ERR_W-1:0] err_cnt_o,
  input logic [7:0]       led_mask,
  input logic [$clog2(FWD_DEPTH+1)-1:0] cnt_q
);
  AST_TR_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    tr_rst_o |=> !tr_rst_o); // R4
  AST_LED_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(led_mask)); // R5
  AST_ERR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (err_cnt_o == $past(err_cnt_o)) || (err_cnt_o == $past(err_cnt_o) + 1'b1)); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= ($clog2(FWD_DEPTH+1))'(FWD_DEPTH)); // R11
  AST_FWD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid_o && !fwd_ready_i) |=> (fwd_valid_o && $stable(fwd_data_o))); // R11
endmodule

bind sc_cmd_parser sc_cmd_parser_chk #(.FWD_DEPTH(FWD_DEPTH), .ERR_W(ERR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tr_rst_o(tr_rst_o), .fwd_valid_o(fwd_valid_o),
  .fwd_ready_i(fwd_ready_i), .fwd_data_o(fwd_data_o), .err_cnt_o(err_cnt_o),
  .led_mask(led_mask), .cnt_q(cnt_q)
);

// File: tb/test_sc_cmd_parser.sv
`timescale 1ns/1ps
module test_sc_cmd_parser;
  localparam int D = 3;
  localparam int DEPTH = 4;

  logic clk = 1'b0, rst_n = 1'b0, rx_valid = 1'b0, fwd_ready = 1'b0;
  logic [7:0] rx_byte = '0;
  logic [7:0] dio, err;
  logic tr_rst, fwd_valid;
  logic [31:0] fwd_data;
  int nchk = 0, nerr = 0, exp_err = 0;

  always #10 clk = ~clk;

  sc_cmd_parser i_sc_cmd_parser (
    .clk(clk), .rst_n(rst_n), .rx_valid_i(rx_valid), .rx_byte_i(rx_byte),
    .dio_o(dio), .tr_rst_o(tr_rst), .fwd_valid_o(fwd_valid), .fwd_data_o(fwd_data),
    .fwd_ready_i(fwd_ready), .err_cnt_o(err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    rx_valid = 1'b1; rx_byte = b;
    @(negedge clk);
  endtask

  task automatic frame(input logic [7:0] op, input logic [7:0] arg, input bit bad);
    put(8'hA5); put(op); put(arg); put(8'(op + arg + (bad ? 8'd1 : 8'd0)));
    rx_valid = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pop_expect(input logic [31:0] exp, input string req);
    chk(fwd_valid === 1'b1, req, "fwd_valid", 32'(fwd_valid), 1);
    chk(fwd_data === exp, req, "fwd_data", fwd_data, exp);
    fwd_ready = 1'b1; @(negedge clk); fwd_ready = 1'b0;
  endtask

  task automatic led_sweep(input logic [7:0] arg, input int len, input logic [7:0] base,
                           input string req);
    frame(8'h81, arg, 1'b0);
    for (int k = 0; k < D + len + 2; k++) begin
      logic [7:0] e;
      e = base | ((k >= D && k < D + len) ? (8'd1 << arg[2:0]) : 8'd0);
      chk(dio === e, req, $sformatf("dio k=%0d", k), 32'(dio), 32'(e));
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    wait_n(3);
    chk(dio === 8'h00, "R1", "dio", 32'(dio), 0);
    chk(tr_rst === 1'b0, "R1", "tr_rst", 32'(tr_rst), 0);
    chk(fwd_valid === 1'b0, "R1", "fwd_valid", 32'(fwd_valid), 0);
    chk(err === 8'h00, "R1", "err", 32'(err), 0);
    rst_n = 1'b1; wait_n(2);

    // R4 time-register reset
    frame(8'h80, 8'h33, 1'b0);
    chk(tr_rst === 1'b1, "R4", "tr_rst k=0", 32'(tr_rst), 1);
    chk(fwd_valid === 1'b0, "R4", "not forwarded", 32'(fwd_valid), 0);
    wait_n(1);
    chk(tr_rst === 1'b0, "R4", "tr_rst k=1", 32'(tr_rst), 0);

    // R6 default length, R5 sweep over lines and lengths
    led_sweep(8'hF8, 4, 8'h00, "R6");
    for (int len = 0; len < 7; len += 3) begin
      frame(8'h82, 8'(len), 1'b0);
      for (int line = 0; line < 8; line++)
        led_sweep({5'(len * 7 + line), 3'(line)}, (len == 0) ? 1 : len, 8'h00, "R5");
    end

    // R7 static levels with pulse
    frame(8'h82, 8'd2, 1'b0);
    frame(8'h83, 8'h5A, 1'b0);
    chk(dio === 8'h5A, "R7", "static", 32'(dio), 32'h5A);
    led_sweep(8'h00, 2, 8'h5A, "R7");
    frame(8'h83, 8'h00, 1'b0);
    chk(dio === 8'h00, "R7", "static clear", 32'(dio), 0);

    // R8 LED while busy
    frame(8'h82, 8'd20, 1'b0);
    frame(8'h81, 8'h02, 1'b0);
    wait_n(4);
    frame(8'h81, 8'h05, 1'b0);
    wait_n(D + 1);
    chk(dio === 8'h04, "R8", "first pulse only", 32'(dio), 32'h04);
    wait_n(25);
    chk(dio === 8'h00, "R8", "no late pulse", 32'(dio), 0);
    frame(8'h82, 8'd4, 1'b0);
    led_sweep(8'h05, 4, 8'h00, "R8");

    // R3 bad checksums
    frame(8'h80, 8'h00, 1'b1); exp_err++;
    chk(tr_rst === 1'b0, "R3", "no tr_rst", 32'(tr_rst), 0);
    chk(err === 8'(exp_err), "R3", "err", 32'(err), 32'(exp_err));
    frame(8'h81, 8'h01, 1'b1); exp_err++;
    frame(8'h10, 8'h01, 1'b1); exp_err++;
    wait_n(D + 2);
    chk(dio === 8'h00, "R3", "no led", 32'(dio), 0);
    chk(fwd_valid === 1'b0, "R3", "no forward", 32'(fwd_valid), 0);
    chk(err === 8'(exp_err), "R3", "err", 32'(err), 32'(exp_err));

    // R2 stray bytes and gaps
    put(8'h00); put(8'h5A); put(8'hFF); rx_valid = 1'b0; wait_n(2);
    put(8'hA5); rx_valid = 1'b0; wait_n(3);
    put(8'h42); rx_valid = 1'b0; wait_n(1);
    put(8'h07); put(8'h49); rx_valid = 1'b0;
    pop_expect(32'hA5420749, "R2");
    chk(err === 8'(exp_err), "R2", "err unchanged", 32'(err), 32'(exp_err));

    // R9 / R10 opcode sweep
    for (int op = 0; op < 256; op++) begin
      logic [7:0] o, a;
      o = 8'(op); a = o ^ 8'h3C;
      if (o >= 8'h80 && o <= 8'h83) continue;
      frame(o, a, 1'b0);
      if (o[7:4] == 4'h8) begin
        chk(fwd_valid === 1'b0, "R9", $sformatf("op %0h fwd", o), 32'(fwd_valid), 0);
        chk(tr_rst === 1'b0, "R9", "tr_rst", 32'(tr_rst), 0);
        wait_n(D + 1);
        chk(dio === 8'h00, "R9", "dio", 32'(dio), 0);
      end else begin
        pop_expect({8'hA5, o, a, 8'(o + a)}, "R10");
      end
    end

    // R11 full FIFO drops whole frames
    for (int i = 0; i < DEPTH + 2; i++) frame(8'(8'h20 + i), 8'(i), 1'b0);
    wait_n(2);
    chk(fwd_data === 32'hA5200020, "R11", "head stable", fwd_data, 32'hA5200020);
    for (int i = 0; i < DEPTH; i++)
      pop_expect({8'hA5, 8'(8'h20 + i), 8'(i), 8'(8'h20 + 2 * i)}, "R11");
    chk(fwd_valid === 1'b0, "R11", "dropped frames absent", 32'(fwd_valid), 0);

    // R3 saturation
    for (int i = 0; i < 260; i++) begin frame(8'h11, 8'h22, 1'b1); exp_err++; end
    chk(err === 8'((exp_err > 255) ? 255 : exp_err), "R3", "saturate", 32'(err), 255);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule